// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block moves a byte stream between a device-side buffer and host memory by following a table of region descriptors kept in host memory. It is given the table's base address, the number of bytes the device buffer holds and a direction. After a start pulse it fetches descriptors one at a time over a 32-bit memory port with a valid/ready handshake. Each descriptor is two 32-bit words: the region address comes first and a size/flags word follows. The block then issues one data beat per 32-bit word of the region. It reads from memory toward the device, or writes the device's words into memory.

A walk ends in one of two ways. It reports done once the device buffer has been fully drained. It reports a short table when the descriptors run out first. The descriptors run out either at a descriptor marked final or after one 4 KiB page of descriptors has been consumed. Region addresses are assumed to be word aligned. Region lengths are always even, so a beat carries either four bytes or a two-byte tail.

Top module: `sg_walker`

## Requirements
- R1: After start the first memory access is a read of the word at the table base with bits 1:0 cleared. Each descriptor is fetched as a read of pointer+0 (region address) then pointer+4 (size word), both with byte enables 4'b1111. The pointer then advances by 8.
- R2: A region's byte count is the size word ANDed with 0xFFFE, so bit 0 and bits 30:16 have no effect on the count.
- R3: A masked count of zero gives a region of 65536 bytes.
- R4: Bit 31 of the size word marks the final descriptor. If that region is used up while device bytes remain, the walk ends with a one-cycle table_short pulse, and no further descriptor is fetched.
- R5: No descriptor is fetched once the pointer is 4096 or more bytes past the base. If the device buffer is not yet drained at that point, the walk ends with table_short.
- R6: Each data beat moves min(bytes left in the device buffer, bytes left in the region, 4) bytes at the current region address. Byte enables are 4'b1111 for 4 bytes and 4'b0011 for 2 bytes, and the region address then advances by that count.
- R7: When the device buffer count reaches zero, done pulses for one cycle and busy drops. When that happens in the same step as the final region running out, the result is done and not table_short. A byte count of zero gives done with no memory access.
- R8: With to_host=1 each beat is a memory write whose data is dev_in_data, and dev_in_take pulses on its acceptance. With to_host=0 each beat is a memory read whose response appears on dev_out_data with dev_out_valid and the beat's byte enables.
- R9: A start pulse while busy has no effect on the walk in progress. A new start clears any region left over from the last walk, so the new walk begins with a fresh descriptor fetch.
- R10: While rst_n is low at a clock edge the block becomes idle: busy, done, table_short and mem_req_valid are low.
- R11: A request that is not accepted stays valid with the same address until mem_req_ready is high, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (honoured only when idle) |
| table_base | input | 32 | Byte address of the descriptor table |
| xfer_len | input | 24 | Bytes held by the device buffer for this walk |
| to_host | input | 1 | 1: device to memory (writes), 0: memory to device (reads) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: device buffer drained |
| table_short | output | 1 | One-cycle pulse: table ended before the buffer drained |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request word address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| dev_in_data | input | 32 | Head word of the device buffer (device to memory) |
| dev_in_take | output | 1 | Head word consumed |
| dev_out_valid | output | 1 | Word for the device is valid |
| dev_out_data | output | 32 | Word for the device |
| dev_out_be | output | 4 | Valid bytes of dev_out_data |

## Verification
The two endings can meet in one decision: the device buffer drains in the same step that the final region runs out. Two tables provoke this. One is read toward the device and ends on a two-byte tail. The other is written from the device, with lengths summing exactly to the buffer count. In both the bench model expects done with no table_short. A start pulse injected mid-walk, and a second walk over a table whose last region was left partly unused, show that a start while busy and leftover region state from an earlier walk leave no trace in the observed request sequence.

// File: rtl/sgw_pkg.sv
// Shared definitions for the scatter-gather descriptor walker.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package sgw_pkg;

    // Walker control states.
    typedef enum logic [2:0] {
        ST_IDLE,       // waiting for start
        ST_DECIDE,     // choose: finish, fail, move data or fetch descriptor
        ST_ADR_REQ,    // issue read of descriptor word 0
        ST_ADR_WAIT,   // wait for region address
        ST_SIZE_REQ,   // issue read of descriptor word 1
        ST_SIZE_WAIT,  // wait for size/flags word
        ST_BEAT_REQ,   // issue a data beat
        ST_BEAT_WAIT   // wait for read data of a beat
    } sgw_state_e;

    localparam int unsigned SGW_DESC_BYTES = 8;
    localparam int unsigned SGW_WORD_BYTES = 4;

endpackage

// File: rtl/sgw_len_decode.sv
// Decodes a descriptor size/flags word into a region byte count and a final flag.
// Assumes the count field occupies bits CNT_W-1:1 and that zero means 2**CNT_W bytes.
module sgw_len_decode #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned LAST_BIT = 31,
    localparam int unsigned LEN_W   = CNT_W + 1
) (
    input  logic [DATA_W-1:0] size_word,
    output logic [LEN_W-1:0]  region_len,
    output logic              region_last
);

    logic [CNT_W-2:0] half_count;
    logic             unused_size_bits;

    // Extract the even byte count and map zero to the full range.
    always_comb begin
        half_count = size_word[CNT_W-1:1];
        if (half_count == '0) begin
            region_len = {1'b1, {CNT_W{1'b0}}};
        end else begin
            region_len = {1'b0, half_count, 1'b0};
        end
        region_last = size_word[LAST_BIT];
    end

    // Bits outside the count and final flag carry no meaning here.
    assign unused_size_bits = ^{size_word[0], size_word[DATA_W-1:CNT_W]};

endmodule

// File: rtl/sgw_beat_sel.sv
// Chooses the byte count and byte enables of the next data beat.
// Assumes both counts are even and the region address is word aligned.
module sgw_beat_sel #(
    parameter int unsigned XFER_W     = 24,
    parameter int unsigned LEN_W      = 17,
    parameter int unsigned BEAT_BYTES = 4,
    localparam int unsigned CW        = $clog2(BEAT_BYTES) + 1
) (
    input  logic [XFER_W-1:0]     bytes_left,
    input  logic [LEN_W-1:0]      region_left,
    output logic [CW-1:0]         beat_bytes,
    output logic [BEAT_BYTES-1:0] beat_be
);

    // Smallest of device bytes left, region bytes left and one full word.
    always_comb begin
        beat_bytes = CW'(BEAT_BYTES);
        if (bytes_left < XFER_W'(BEAT_BYTES)) begin
            beat_bytes = bytes_left[CW-1:0];
        end
        if ((region_left < LEN_W'(BEAT_BYTES)) && (region_left[CW-1:0] < beat_bytes)) begin
            beat_bytes = region_left[CW-1:0];
        end
    end

    // One enable per byte lane below the beat size.
    for (genvar lane = 0; lane < BEAT_BYTES; lane++) begin : g_lane
        assign beat_be[lane] = (CW'(lane) < beat_bytes);
    end

endmodule

// File: rtl/sgw_region_track.sv
// Holds the current region address, remaining region length and final flag.
// Assumes load strobes and the advance strobe are never raised together.
module sgw_region_track #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 17,
    parameter int unsigned CW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic              load_size,
    input  logic [LEN_W-1:0]  new_len,
    input  logic              new_last,
    input  logic              advance,
    input  logic [CW-1:0]     step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_len,
    output logic              cur_last
);

    // Region state: cleared on reset or start, loaded per descriptor, stepped per beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_addr <= '0;
            cur_len  <= '0;
            cur_last <= 1'b0;
        end else begin
            if (load_addr) begin
                cur_addr <= new_addr;
            end
            if (load_size) begin
                cur_len  <= new_len;
                cur_last <= new_last;
            end
            if (advance) begin
                cur_addr <= cur_addr + ADDR_W'(step);
                cur_len  <= cur_len - LEN_W'(step);
            end
        end
    end

endmodule

// File: rtl/sgw_walk_ctrl.sv
// Sequences descriptor fetches and data beats, tracks the table pointer and
// the device byte count, and decides when a walk finishes or fails.
// Assumes a single outstanding memory read and responses in request order.
module sgw_walk_ctrl
    import sgw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned XFER_W     = 24,
    parameter int unsigned LEN_W      = 17,
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned BEAT_BYTES = 4,
    localparam int unsigned CW        = $clog2(BEAT_BYTES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     table_base,
    input  logic [XFER_W-1:0]     xfer_len,
    input  logic                  to_host,
    input  logic [ADDR_W-1:0]     region_addr,
    input  logic [LEN_W-1:0]      region_left,
    input  logic                  region_last,
    input  logic [CW-1:0]         beat_bytes,
    input  logic [BEAT_BYTES-1:0] beat_be,
    input  logic                  mem_req_ready,
    input  logic                  mem_rsp_valid,
    output logic                  busy,
    output logic                  done,
    output logic                  table_short,
    output logic                  mem_req_valid,
    output logic                  mem_req_write,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [BEAT_BYTES-1:0] mem_req_be,
    output logic                  dev_in_take,
    output logic                  dev_out_valid,
    output logic [XFER_W-1:0]     bytes_left,
    output logic                  region_clear,
    output logic                  load_addr,
    output logic                  load_size,
    output logic                  beat_done
);

    sgw_state_e        state;
    logic [ADDR_W-1:0] desc_ptr;
    logic [ADDR_W-1:0] base_q;
    logic              dir_q;
    logic              page_used;
    logic              drained;
    logic              table_out;
    logic [ADDR_W-1:0] base_aligned;
    logic              unused_base_bits;

    assign base_aligned     = {table_base[ADDR_W-1:2], 2'b00};
    assign unused_base_bits = ^table_base[1:0];

    // Decision inputs evaluated in the decide state.
    assign page_used = (desc_ptr - base_q) >= ADDR_W'(PAGE_BYTES);
    assign drained   = (bytes_left == '0);
    assign table_out = (region_left == '0) && (region_last || page_used);

    // Completion pulses; draining takes priority over running out of table.
    assign done        = (state == ST_DECIDE) && drained;
    assign table_short = (state == ST_DECIDE) && !drained && table_out;
    assign busy        = (state != ST_IDLE);

    // Strobes toward the region tracker.
    assign region_clear = (state == ST_IDLE) && start;
    assign load_addr    = (state == ST_ADR_WAIT) && mem_rsp_valid;
    assign load_size    = (state == ST_SIZE_WAIT) && mem_rsp_valid;
    assign beat_done    = ((state == ST_BEAT_REQ) && dir_q && mem_req_ready) ||
                          ((state == ST_BEAT_WAIT) && mem_rsp_valid);

    // Memory request fields by state.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = desc_ptr;
        mem_req_be    = '1;
        case (state)
            ST_ADR_REQ: begin
                mem_req_valid = 1'b1;
            end
            ST_SIZE_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_ptr + ADDR_W'(SGW_WORD_BYTES);
            end
            ST_BEAT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = dir_q;
                mem_req_addr  = region_addr;
                mem_req_be    = beat_be;
            end
            default: begin
                mem_req_valid = 1'b0;
            end
        endcase
    end

    // Device-side strobes.
    assign dev_in_take   = (state == ST_BEAT_REQ) && dir_q && mem_req_ready;
    assign dev_out_valid = (state == ST_BEAT_WAIT) && mem_rsp_valid;

    // Walk state, table pointer, device count and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            desc_ptr   <= '0;
            base_q     <= '0;
            bytes_left <= '0;
            dir_q      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        desc_ptr   <= base_aligned;
                        base_q     <= base_aligned;
                        bytes_left <= xfer_len;
                        dir_q      <= to_host;
                        state      <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (drained || table_out) begin
                        state <= ST_IDLE;
                    end else if (region_left != '0) begin
                        state <= ST_BEAT_REQ;
                    end else begin
                        state <= ST_ADR_REQ;
                    end
                end
                ST_ADR_REQ: begin
                    if (mem_req_ready) begin
                        state <= ST_ADR_WAIT;
                    end
                end
                ST_ADR_WAIT: begin
                    if (mem_rsp_valid) begin
                        state <= ST_SIZE_REQ;
                    end
                end
                ST_SIZE_REQ: begin
                    if (mem_req_ready) begin
                        state <= ST_SIZE_WAIT;
                    end
                end
                ST_SIZE_WAIT: begin
                    if (mem_rsp_valid) begin
                        desc_ptr <= desc_ptr + ADDR_W'(SGW_DESC_BYTES);
                        state    <= ST_DECIDE;
                    end
                end
                ST_BEAT_REQ: begin
                    if (mem_req_ready) begin
                        if (dir_q) begin
                            bytes_left <= bytes_left - XFER_W'(beat_bytes);
                            state      <= ST_DECIDE;
                        end else begin
                            state <= ST_BEAT_WAIT;
                        end
                    end
                end
                ST_BEAT_WAIT: begin
                    if (mem_rsp_valid) begin
                        bytes_left <= bytes_left - XFER_W'(beat_bytes);
                        state      <= ST_DECIDE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sg_walker.sv
// Scatter-gather descriptor walker: follows a descriptor table in host memory
// and moves the device buffer's bytes to or from the regions it lists.
// Assumes word-aligned region addresses and a 32-bit in-order memory port.
module sg_walker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned XFER_W     = 24,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned LAST_BIT   = 31,
    parameter int unsigned PAGE_BYTES = 4096,
    localparam int unsigned LEN_W     = CNT_W + 1,
    localparam int unsigned BEAT_B    = DATA_W / 8,
    localparam int unsigned CW        = $clog2(BEAT_B) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] table_base,
    input  logic [XFER_W-1:0] xfer_len,
    input  logic              to_host,
    output logic              busy,
    output logic              done,
    output logic              table_short,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic [BEAT_B-1:0] mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_take,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    output logic [BEAT_B-1:0] dev_out_be
);

    logic [LEN_W-1:0]  dec_len;
    logic              dec_last;
    logic [ADDR_W-1:0] region_addr;
    logic [LEN_W-1:0]  region_left;
    logic              region_last;
    logic [CW-1:0]     beat_bytes;
    logic [BEAT_B-1:0] beat_be;
    logic [XFER_W-1:0] bytes_left;
    logic              region_clear;
    logic              load_addr;
    logic              load_size;
    logic              beat_done;

    sgw_len_decode #(
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .LAST_BIT (LAST_BIT)
    ) u_decode (
        .size_word   (mem_rsp_data),
        .region_len  (dec_len),
        .region_last (dec_last)
    );

    sgw_region_track #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CW     (CW)
    ) u_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (region_clear),
        .load_addr (load_addr),
        .new_addr  (mem_rsp_data[ADDR_W-1:0]),
        .load_size (load_size),
        .new_len   (dec_len),
        .new_last  (dec_last),
        .advance   (beat_done),
        .step      (beat_bytes),
        .cur_addr  (region_addr),
        .cur_len   (region_left),
        .cur_last  (region_last)
    );

    sgw_beat_sel #(
        .XFER_W     (XFER_W),
        .LEN_W      (LEN_W),
        .BEAT_BYTES (BEAT_B)
    ) u_beat (
        .bytes_left  (bytes_left),
        .region_left (region_left),
        .beat_bytes  (beat_bytes),
        .beat_be     (beat_be)
    );

    sgw_walk_ctrl #(
        .ADDR_W     (ADDR_W),
        .XFER_W     (XFER_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BEAT_BYTES (BEAT_B)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .table_base    (table_base),
        .xfer_len      (xfer_len),
        .to_host       (to_host),
        .region_addr   (region_addr),
        .region_left   (region_left),
        .region_last   (region_last),
        .beat_bytes    (beat_bytes),
        .beat_be       (beat_be),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .busy          (busy),
        .done          (done),
        .table_short   (table_short),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_be    (mem_req_be),
        .dev_in_take   (dev_in_take),
        .dev_out_valid (dev_out_valid),
        .bytes_left    (bytes_left),
        .region_clear  (region_clear),
        .load_addr     (load_addr),
        .load_size     (load_size),
        .beat_done     (beat_done)
    );

    // Data paths pass straight through: write data from the device, read data to it.
    assign mem_req_wdata = dev_in_data;
    assign dev_out_data  = mem_rsp_data;
    assign dev_out_be    = beat_be;

endmodule

// File: rtl/sg_walker_chk.sv
// Protocol checker for the descriptor walker, bound to its ports.
// Assumes the synchronous active-low reset of the walker.
module sg_walker_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BEAT_B = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              table_short,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [BEAT_B-1:0] mem_req_be,
    input logic              mem_rsp_valid,
    input logic              dev_in_take,
    input logic              dev_out_valid
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))) else $error("request dropped"); // R11

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && table_short)) else $error("done and table_short together"); // R7

    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || table_short) |=> !busy) else $error("still busy after end"); // R7

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_be == 4'b1111 || mem_req_be == 4'b0011)) else $error("bad byte enables"); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid) else $error("request while idle"); // R10

    AST_TAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_take |-> (mem_req_valid && mem_req_ready && mem_req_write)) else $error("take without write"); // R8

    AST_OUT_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_valid |-> mem_rsp_valid) else $error("device word without response"); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done && !table_short) |=> busy) else $error("start disturbed walk"); // R9

endmodule

bind sg_walker sg_walker_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_B (BEAT_B)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .table_short   (table_short),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_be    (mem_req_be),
    .mem_rsp_valid (mem_rsp_valid),
    .dev_in_take   (dev_in_take),
    .dev_out_valid (dev_out_valid)
);

// File: tb/tb_sg_walker.sv
// Bench for the descriptor walker: a behavioural model predicts every memory
// request and device word; each clock the observed traffic is compared.
module tb_sg_walker;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [31:0] table_base;
    logic [23:0] xfer_len;
    logic        to_host;
    logic        busy, done, table_short;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic [31:0] dev_in_data;
    logic        dev_in_take, dev_out_valid;
    logic [31:0] dev_out_data;
    logic [3:0]  dev_out_be;

    sg_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
        .xfer_len(xfer_len), .to_host(to_host), .busy(busy), .done(done),
        .table_short(table_short), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_be(mem_req_be), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .dev_in_data(dev_in_data),
        .dev_in_take(dev_in_take), .dev_out_valid(dev_out_valid),
        .dev_out_data(dev_out_data), .dev_out_be(dev_out_be)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        bit          wr;
        bit          desc;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
    } txn_t;

    typedef struct {
        logic [31:0] data;
        logic [3:0]  be;
    } dout_t;

    logic [31:0] mem [logic [31:0]];
    txn_t        exp_q [$];
    dout_t       out_q [$];
    int          exp_end;
    string       cur_tag;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          widx = 0;
    bit          take_pend = 0;
    bit          rsp_pend = 0;
    logic [31:0] rsp_addr;
    bit          hold_pend = 0;
    logic [31:0] hold_addr;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] pat(input int k);
        return 32'hC0DE_0000 + 32'(k);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural prediction of one walk.
    task automatic model(input logic [31:0] base, input int len, input bit wr);
        logic [31:0] b0, p, ra, sz;
        int rem, rl, c, wk;
        bit lst;
        txn_t t;
        dout_t d;
        b0 = {base[31:2], 2'b00};
        p = b0; rem = len; rl = 0; lst = 0; ra = 0; wk = 0;
        exp_q.delete();
        out_q.delete();
        forever begin
            if (rem == 0) begin exp_end = 1; break; end
            if (rl == 0) begin
                if (lst || (p - b0) >= 32'd4096) begin exp_end = 2; break; end
                t = '{wr: 0, desc: 1, addr: p, be: 4'hF, wdata: 0};
                exp_q.push_back(t);
                t.addr = p + 4;
                exp_q.push_back(t);
                ra = rd(p);
                sz = rd(p + 4);
                rl = int'(sz & 32'h0000_FFFE);
                if (rl == 0) rl = 65536;
                lst = sz[31];
                p = p + 8;
                continue;
            end
            c = 4;
            if (rem < c) c = rem;
            if (rl < c) c = rl;
            t.wr = wr; t.desc = 0; t.addr = ra;
            t.be = 4'((1 << c) - 1);
            t.wdata = wr ? pat(wk) : 32'h0;
            exp_q.push_back(t);
            if (wr) begin
                wk++;
            end else begin
                d.data = rd(ra);
                d.be = t.be;
                out_q.push_back(d);
            end
            ra = ra + 32'(c);
            rl -= c;
            rem -= c;
        end
    endtask

    // Memory and device model; compares traffic against the prediction each clock.
    always @(negedge clk) begin
        txn_t e;
        dout_t d;
        string tg;
        cyc++;
        if (take_pend) begin
            widx++;
            dev_in_data = pat(widx);
            take_pend = 0;
        end
        mem_rsp_valid = 1'b0;
        if (rsp_pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = rd(rsp_addr);
            rsp_pend = 0;
        end
        mem_req_ready = ((cyc % 3) != 2);
        #1;
        if (hold_pend) begin
            chk(mem_req_valid === 1'b1 && mem_req_addr == hold_addr, "R11",
                "request held", mem_req_addr, hold_addr);
            hold_pend = 0;
        end
        if (dev_out_valid === 1'b1) begin
            if (out_q.size() == 0) begin
                chk(0, "R8", "unexpected device word", dev_out_data, 0);
            end else begin
                d = out_q.pop_front();
                chk(dev_out_data == d.data, "R8", "device word", dev_out_data, d.data);
                chk(dev_out_be == d.be, "R6", "device byte enables", {28'h0, dev_out_be}, {28'h0, d.be});
            end
        end
        if (mem_req_valid === 1'b1) begin
            if (mem_req_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R1", "unexpected request", mem_req_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    tg = e.desc ? "R1" : cur_tag;
                    chk(mem_req_write == e.wr, tg, "request kind", {31'h0, mem_req_write}, {31'h0, e.wr});
                    chk(mem_req_addr == e.addr, tg, "request address", mem_req_addr, e.addr);
                    chk(mem_req_be == e.be, "R6", "request byte enables", {28'h0, mem_req_be}, {28'h0, e.be});
                    if (e.wr) begin
                        chk(mem_req_wdata == e.wdata, "R8", "write data", mem_req_wdata, e.wdata);
                    end
                end
                if (mem_req_write) begin
                    chk(dev_in_take === 1'b1, "R8", "take on write", {31'h0, dev_in_take}, 1);
                    take_pend = 1;
                end else begin
                    rsp_pend = 1;
                    rsp_addr = mem_req_addr;
                end
            end else begin
                hold_pend = 1;
                hold_addr = mem_req_addr;
            end
        end
    end

    task automatic run_walk(input logic [31:0] base, input int len, input bit wr,
                            input bit inj, input string tag, input string end_tag);
        bit fin;
        model(base, len, wr);
        cur_tag = tag;
        widx = 0;
        dev_in_data = pat(0);
        @(negedge clk);
        table_base = base;
        xfer_len = 24'(len);
        to_host = wr;
        start = 1'b1;
        fin = 0;
        for (int n = 0; n < 20000 && !fin; n++) begin
            @(negedge clk);
            start = (inj && n == 3);
            if (inj && n == 3) table_base = 32'h0000_1300;
            #2;
            if (done === 1'b1 || table_short === 1'b1) begin
                fin = 1;
                chk((done === 1'b1 ? 1 : 2) == exp_end, end_tag, "walk outcome",
                    {31'h0, table_short}, 32'(exp_end - 1));
            end
        end
        start = 1'b0;
        if (!fin) chk(0, end_tag, "watchdog expired", 0, 1);
        chk(exp_q.size() == 0, tag, "requests left unissued", 32'(exp_q.size()), 0);
        chk(out_q.size() == 0, tag, "device words missing", 32'(out_q.size()), 0);
        @(negedge clk);
        #2;
        chk(busy === 1'b0, end_tag, "idle after end", {31'h0, busy}, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        table_base = '0;
        xfer_len = '0;
        to_host = 1'b0;
        dev_in_data = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        mem_req_ready = 1'b0;
        cur_tag = "R1";

        // Descriptor tables.
        mem[32'h1000] = 32'h2000; mem[32'h1004] = 32'h0000_0008;
        mem[32'h1008] = 32'h2100; mem[32'h100C] = 32'h8000_0006;
        mem[32'h1100] = 32'h2200; mem[32'h1104] = 32'h8000_0007;
        mem[32'h1200] = 32'h2400; mem[32'h1204] = 32'h8001_0000;
        mem[32'h1300] = 32'h2600; mem[32'h1304] = 32'h0000_0004;
        mem[32'h1308] = 32'h2700; mem[32'h130C] = 32'h8000_0004;
        mem[32'h1400] = 32'h3000; mem[32'h1404] = 32'h0000_0006;
        mem[32'h1408] = 32'h3100; mem[32'h140C] = 32'h8000_000A;
        mem[32'h1600] = 32'h2800; mem[32'h1604] = 32'h8000_0010;
        for (int i = 0; i < 512; i++) begin
            mem[32'h0001_0000 + 32'(8 * i)] = 32'h0004_0000 + 32'(16 * i);
            mem[32'h0001_0004 + 32'(8 * i)] = 32'h0000_0002;
        end

        repeat (3) @(negedge clk);
        #2;
        chk(busy === 1'b0 && done === 1'b0 && table_short === 1'b0, "R10",
            "reset flags", {29'h0, busy, done, table_short}, 0);
        chk(mem_req_valid === 1'b0, "R10", "no request in reset", {31'h0, mem_req_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        run_walk(32'h1000, 14, 0, 0, "R6", "R7");         // two regions, 2-byte tail, drain meets final
        run_walk(32'h1102, 6, 0, 0, "R2", "R7");          // bit 0 ignored, base low bits cleared
        run_walk(32'h1200, 12, 0, 0, "R3", "R7");         // zero count means 65536
        run_walk(32'h1300, 12, 0, 0, "R4", "R4");         // final region ends early
        run_walk(32'h1400, 16, 1, 0, "R8", "R7");         // device to memory writes
        run_walk(32'h1500, 0, 0, 0, "R7", "R7");          // empty buffer
        run_walk(32'h1600, 4, 0, 0, "R9", "R7");          // leaves part of a region
        run_walk(32'h1600, 4, 0, 0, "R9", "R9");          // restart must refetch
        run_walk(32'h1000, 14, 0, 1, "R9", "R9");         // start while busy ignored
        run_walk(32'h0001_0000, 2000, 1, 0, "R5", "R5");  // page limit

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule